// File: doc/BRIEF.md
# Gated Transmit PCM Serial Port

This block sends one 8-bit companded voice sample per frame on a serial data pin. The pin has a separate output enable, so a pad can be three-stated. A single enable input does two jobs. It opens the pin, and it gates the serial data clock: a bit moves only on a rising edge of the product of enable and data clock. The frame is marked by an 8 kHz sync input. The first rising edge of the enable after a rising edge of the sync is the transmit strobe. That strobe requests a new sample from the conversion engine, which sits outside this block, and loads the waiting word into the shift register with the sign bit at the front.

The shift register is a ring. Its output bit feeds back into its input, so a host can read the same word several times within one frame. Two access styles are supported. In the byte-wide style the host holds the enable high for eight clock periods. In the bit-wide style the host pulses the enable once per bit, and clock rises that fall outside those pulses do nothing. The serial clock, the enable, the sync and the power-down pin are all treated as asynchronous levels. A faster core clock samples them through a synchronizer, and every edge is detected in the core clock domain.

A power-down input freezes the port and forces the pin to high impedance. Once power-down is released, the pin stays high impedance until two sync rising edges have been seen.

Top module: `tx_pcm_port`

## Requirements
- R1: After reset, `dout_oe_o` is 0, `dout_o` is 0 and `conv_req_o` is 0.
- R2: `dout_oe_o` is 1 exactly while the enable is high, power-down is low and the port is fully awake. It returns to 0 when the enable falls.
- R3: The first enable rise after a sync rise produces a one-cycle `conv_req_o` pulse and loads `word_i` into the shift register. `dout_o` then shows bit 7 (the sign bit).
- R4: An enable rise with no new sync rise before it produces no request and loads nothing. A change on `word_i` then has no effect on `dout_o`.
- R5: The first rising edge of (enable AND data clock) at or after a load leaves the loaded bit 7 on `dout_o`. Each later such edge rotates the register left by one, bit 7 going to bit 0, and `dout_o` always shows bit 7.
- R6: If the enable is held high across eight data clock rises, starting on the rise at which it goes high, the word appears on `dout_o` bit 7 first and bit 0 last.
- R7: The register recirculates. A second eight-rise read in the same frame reproduces the same word, bit 7 first.
- R8: If the enable is pulsed high around a single clock rise for each bit, the word still comes out bit 7 first. Clock rises while the enable is low do not shift.
- R9: While power-down is high, `dout_oe_o` is 0, `conv_req_o` stays 0, and clock, enable and sync activity leave `dout_o` unchanged.
- R10: After power-down falls, `dout_oe_o` stays 0 even with the enable high until the second sync rise has been seen. Enable rises during this wait still load and request.
- R11: `conv_req_o` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples all port inputs |
| rst | input | 1 | Synchronous active-high reset |
| dclk_i | input | 1 | Serial data clock, asynchronous level |
| txen_i | input | 1 | Enable: opens the output and gates the shift clock |
| msync_i | input | 1 | 8 kHz frame sync |
| pd_i | input | 1 | Power-down, active high |
| word_i | input | WORD_W | Next sample from the conversion engine |
| dout_o | output | 1 | Serial data bit (front of the register) |
| dout_oe_o | output | 1 | Output enable for the three-state pad |
| conv_req_o | output | 1 | One-cycle conversion request at the transmit strobe |

## Verification
The hardest state to reach is the point just after power-down is released. The port is running, but the pin must still stay closed. The stimulus gets there by holding the enable and the clock active during power-down. It then releases power-down and gives one sync pulse followed by an enable rise, which must load and request but leave the pin closed. A second sync then opens the pin for a full read of a fresh word. Before that, the bit-wide read leaves a known bit at the front of the register, so gated clock activity during power-down can be seen directly on the data pin.

// File: rtl/tx_pcm_pkg.sv
package tx_pcm_pkg;

    typedef enum logic [1:0] {
        PW_ON   = 2'd0,
        PW_OFF  = 2'd1,
        PW_WAKE = 2'd2
    } pw_state_e;

    typedef struct packed {
        logic sync_rise;
        logic en_rise;
        logic shift_rise;
        logic en_lvl;
        logic pd_lvl;
    } port_evt_t;

    localparam int unsigned IN_BITS = 4;

    function automatic logic pw_running(pw_state_e s, logic pd);
        return (s != PW_OFF) && !pd;
    endfunction

    function automatic logic pw_visible(pw_state_e s, logic pd);
        return (s == PW_ON) && !pd;
    endfunction

endpackage

// File: rtl/tx_pcm_sync.sv
module tx_pcm_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_chain
            logic [WIDTH-1:0] stg [STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < int'(STAGES); i++) begin
                        stg[i] <= '0;
                    end
                end else begin
                    stg[0] <= d_i;
                    for (int i = 1; i < int'(STAGES); i++) begin
                        stg[i] <= stg[i-1];
                    end
                end
            end
            assign q_o = stg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/tx_pcm_edges.sv
module tx_pcm_edges
    import tx_pcm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      dclk_s,
    input  logic      en_s,
    input  logic      sync_s,
    input  logic      pd_s,
    output port_evt_t evt_o
);

    logic en_p;
    logic gated_p;
    logic sync_p;
    logic gated;

    assign gated = en_s & dclk_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_p    <= 1'b0;
            gated_p <= 1'b0;
            sync_p  <= 1'b0;
        end else begin
            en_p    <= en_s;
            gated_p <= gated;
            sync_p  <= sync_s;
        end
    end

    always_comb begin
        evt_o.sync_rise  = sync_s & ~sync_p;
        evt_o.en_rise    = en_s & ~en_p;
        evt_o.shift_rise = gated & ~gated_p;
        evt_o.en_lvl     = en_s;
        evt_o.pd_lvl     = pd_s;
    end

endmodule

// File: rtl/tx_pcm_ctrl.sv
module tx_pcm_ctrl
    import tx_pcm_pkg::*;
#(
    parameter int unsigned WAKE_SYNCS = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  port_evt_t evt_i,
    output logic      load_o,
    output logic      active_o,
    output logic      oe_o,
    output logic      conv_req_o
);

    localparam int unsigned CNT_W = $clog2(WAKE_SYNCS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_SYNCS - 1);

    pw_state_e        pw_q;
    logic [CNT_W-1:0] wake_cnt_q;
    logic             armed_q;
    logic             req_q;
    logic             strobe;

    assign active_o   = pw_running(pw_q, evt_i.pd_lvl);
    assign strobe     = active_o & armed_q & evt_i.en_rise;
    assign load_o     = strobe;
    assign oe_o       = evt_i.en_lvl & pw_visible(pw_q, evt_i.pd_lvl);
    assign conv_req_o = req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pw_q       <= PW_ON;
            wake_cnt_q <= '0;
        end else if (evt_i.pd_lvl) begin
            pw_q       <= PW_OFF;
            wake_cnt_q <= '0;
        end else begin
            unique case (pw_q)
                PW_OFF: begin
                    pw_q       <= PW_WAKE;
                    wake_cnt_q <= '0;
                end
                PW_WAKE: begin
                    if (evt_i.sync_rise) begin
                        if (wake_cnt_q == CNT_LAST) begin
                            pw_q <= PW_ON;
                        end
                        wake_cnt_q <= wake_cnt_q + 1'b1;
                    end
                end
                default: pw_q <= PW_ON;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            req_q <= strobe;
            if (!active_o) begin
                armed_q <= 1'b0;
            end else begin
                armed_q <= evt_i.sync_rise | (armed_q & ~strobe);
            end
        end
    end

    // R9
    pd_noreq_chk: assert property (@(posedge clk) disable iff (rst)
        evt_i.pd_lvl |=> !conv_req_o);

    // R10
    wake_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (pw_q == PW_OFF) |=> !oe_o);

    // R11
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        conv_req_o |=> !conv_req_o);

endmodule

// File: rtl/tx_pcm_shreg.sv
module tx_pcm_shreg #(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              active_i,
    input  logic              shift_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              bit_o
);

    localparam int unsigned MSB = WORD_W - 1;

    logic [WORD_W-1:0] ring_q;
    logic              fresh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_q  <= '0;
            fresh_q <= 1'b0;
        end else if (load_i) begin
            ring_q  <= word_i;
            fresh_q <= ~shift_i;
        end else if (active_i && shift_i) begin
            if (fresh_q) begin
                fresh_q <= 1'b0;
            end else begin
                ring_q <= {ring_q[MSB-1:0], ring_q[MSB]};
            end
        end
    end

    assign bit_o = ring_q[MSB];

    // R3
    load_word_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (ring_q == $past(word_i)));

    // R7
    recirc_chk: assert property (@(posedge clk) disable iff (rst)
        (active_i && shift_i && !load_i) |=>
            ($countones(ring_q) == $countones($past(ring_q))));

endmodule

// File: rtl/tx_pcm_port.sv
module tx_pcm_port
    import tx_pcm_pkg::*;
#(
    parameter int unsigned WORD_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned WAKE_SYNCS  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dclk_i,
    input  logic              txen_i,
    input  logic              msync_i,
    input  logic              pd_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              dout_o,
    output logic              dout_oe_o,
    output logic              conv_req_o
);

    logic [IN_BITS-1:0] raw_in;
    logic [IN_BITS-1:0] syn_in;
    port_evt_t          evt;
    logic               load;
    logic               active;

    assign raw_in = {pd_i, msync_i, txen_i, dclk_i};

    tx_pcm_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (IN_BITS)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_in),
        .q_o (syn_in)
    );

    tx_pcm_edges u_edges (
        .clk    (clk),
        .rst    (rst),
        .dclk_s (syn_in[0]),
        .en_s   (syn_in[1]),
        .sync_s (syn_in[2]),
        .pd_s   (syn_in[3]),
        .evt_o  (evt)
    );

    tx_pcm_ctrl #(
        .WAKE_SYNCS (WAKE_SYNCS)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .load_o     (load),
        .active_o   (active),
        .oe_o       (dout_oe_o),
        .conv_req_o (conv_req_o)
    );

    tx_pcm_shreg #(
        .WORD_W (WORD_W)
    ) u_shreg (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .active_i (active),
        .shift_i  (evt.shift_rise),
        .word_i   (word_i),
        .bit_o    (dout_o)
    );

    // R9
    pd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        evt.pd_lvl |=> $stable(dout_o));

endmodule

// File: tb/tb_tx_pcm_port.sv
module tb_tx_pcm_port;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 10;
    localparam int LAT        = 6;
    localparam int WD_LIMIT   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dclk = 1'b0;
    logic       en = 1'b0;
    logic       msync = 1'b0;
    logic       pd = 1'b0;
    logic [7:0] word = 8'h00;
    logic       dout;
    logic       dout_oe;
    logic       conv_req;

    tx_pcm_port dut (
        .clk        (clk),
        .rst        (rst),
        .dclk_i     (dclk),
        .txen_i     (en),
        .msync_i    (msync),
        .pd_i       (pd),
        .word_i     (word),
        .dout_o     (dout),
        .dout_oe_o  (dout_oe),
        .conv_req_o (conv_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int    due;
        logic  e_oe;
        logic  e_d;
        bit    chk_d;
        string req;
    } item_t;

    item_t sbq[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    int    req_cnt = 0;
    int    req_run = 0;
    int    req_max = 0;
    bit    done = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && conv_req) begin
            req_cnt <= req_cnt + 1;
            req_run <= req_run + 1;
            if (req_run + 1 > req_max) req_max <= req_run + 1;
        end else begin
            req_run <= 0;
        end
    end

    // monitor: pops expected items once due and compares to the ports
    always @(negedge clk) begin
        if (sbq.size() > 0 && cyc >= sbq[0].due) begin
            item_t it;
            it = sbq.pop_front();
            n_chk++;
            if (dout_oe !== it.e_oe) begin
                n_bad++;
                $display("FAIL %s: dout_oe actual %b expected %b", it.req, dout_oe, it.e_oe);
            end else if (it.chk_d && dout !== it.e_d) begin
                n_bad++;
                $display("FAIL %s: dout actual %b expected %b", it.req, dout, it.e_d);
            end
        end
    end

    task automatic expect_out(input logic oe, input logic d, input bit chk, input string req);
        item_t it;
        it.due   = cyc + LAT;
        it.e_oe  = oe;
        it.e_d   = d;
        it.chk_d = chk;
        it.req   = req;
        sbq.push_back(it);
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (sbq.size() > 0) step(1);
    endtask

    task automatic sync_pulse();
        msync = 1'b1;
        step(HALF);
        msync = 1'b0;
        step(HALF);
    endtask

    task automatic idle_clock(input int n);
        for (int k = 0; k < n; k++) begin
            dclk = 1'b1; step(HALF);
            dclk = 1'b0; step(HALF);
        end
    endtask

    // byte-wide read: enable rises with the first clock rise, held for eight rises
    task automatic byte_read(input logic [7:0] w, input string req);
        for (int i = 0; i < 8; i++) begin
            dclk = 1'b1;
            en   = 1'b1;
            expect_out(1'b1, w[7-i], 1'b1, req);
            step(HALF);
            dclk = 1'b0;
            step(HALF);
        end
        dclk = 1'b1;
        en   = 1'b0;
        expect_out(1'b0, 1'b0, 1'b0, "R2");
        step(HALF);
        dclk = 1'b0;
        step(HALF);
    endtask

    // bit-wide read: enable pulsed around one clock rise per bit
    task automatic bit_read(input logic [7:0] w);
        for (int i = 0; i < 8; i++) begin
            dclk = 1'b1;
            expect_out(1'b0, 1'b0, 1'b0, "R2");
            step(HALF);
            dclk = 1'b0;
            step(HALF/2);
            en = 1'b1;
            expect_out(1'b1, 1'b0, 1'b0, "R2");
            step(HALF - HALF/2);
            dclk = 1'b1;
            expect_out(1'b1, w[7-i], 1'b1, "R8");
            step(HALF);
            dclk = 1'b0;
            en   = 1'b0;
            step(HALF);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(5);
        rst = 1'b0;
        step(2);

        // R1: reset state
        n_chk++;
        if (dout_oe !== 1'b0 || dout !== 1'b0 || conv_req !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: oe/dout/req actual %b%b%b expected 000", dout_oe, dout, conv_req);
        end
        idle_clock(2);

        // R3 R5 R6: strobe, load, byte-wide read of A5
        word = 8'hA5;
        sync_pulse();
        byte_read(8'hA5, "R6");
        drain();
        check_int("R3", req_cnt, 1);

        // R4 R7: word change ignored, second read reproduces A5
        word = 8'h3C;
        idle_clock(2);
        byte_read(8'hA5, "R7");
        drain();
        check_int("R4", req_cnt, 1);

        // R8 R5: bit-wide read of 3D with idle clock rises between bits
        idle_clock(2);
        word = 8'h3D;
        sync_pulse();
        bit_read(8'h3D);
        drain();
        check_int("R3", req_cnt, 2);

        // R9: power-down freezes the register and closes the pin
        idle_clock(2);
        pd = 1'b1;
        step(HALF);
        en = 1'b1;
        idle_clock(3);
        sync_pulse();
        dclk = 1'b1;
        expect_out(1'b0, 1'b1, 1'b1, "R9");
        step(HALF);
        dclk = 1'b0;
        en = 1'b0;
        step(HALF);
        drain();
        check_int("R9", req_cnt, 2);

        // R10: after release, pin stays closed until the second sync rise
        pd = 1'b0;
        idle_clock(2);
        word = 8'h81;
        sync_pulse();
        en = 1'b1;
        expect_out(1'b0, 1'b0, 1'b0, "R10");
        step(HALF);
        en = 1'b0;
        step(HALF);
        drain();
        check_int("R10", req_cnt, 3);
        idle_clock(2);
        word = 8'h6E;
        sync_pulse();
        byte_read(8'h6E, "R10");
        drain();
        check_int("R10", req_cnt, 4);

        // R11: every request pulse lasted one cycle
        check_int("R11", req_max, 1);

        idle_clock(1);
        finish_run();
    end

endmodule